// File: doc/BRIEF.md
# Per-ID Ordered Read Response Checker

This block watches a read request channel and a read response channel and confirms that returning beats follow the ordering rules for tagged reads. A read request names an ID. Each accepted request goes into a small first-in first-out queue that belongs to that ID. The entry keeps an 8-bit signature tag and the burst length. Each returning beat carries an ID, and that ID picks the queue it is checked against. The beat is compared with the oldest entry in that queue. Requests that share an ID must therefore be answered in issue order. Requests with different IDs may complete in any order and may interleave beat by beat.

There is one queue for each ID, so reordering across IDs is never reported as a failure. A single shared FIFO would reject that legal traffic. Faults are reported on four sticky flags: queue overflow, response with no pending request, burst length mismatch and data mismatch. A saturating counter records how many data mismatches have occurred. The checker sits passively next to an interconnect or a slave model. It drives nothing back onto the bus.

Top module: `rd_order_checker`

## Requirements
- R1: A request handshake (`ar_valid` and `ar_ready` both high at a rising edge) for an ID whose queue is not full records `ar_tag` and `ar_len` at the back of that ID's queue. A later correct response to it raises no error.
- R2: Within one ID, each response beat is checked against the oldest outstanding request for that ID. Returning a younger request first therefore produces a data mismatch.
- R3: Responses for different IDs may complete in any order and may interleave beat by beat without raising any error. For example, ID0 is issued before ID1, and ID1's response comes back first.
- R4: Each ID queue holds 4 requests. A request handshake for an ID that already has 4 outstanding requests sets `err_overflow`, and that request is not recorded.
- R5: A response handshake (`r_valid` and `r_ready` high at a rising edge) whose `r_id` has an empty queue sets `err_unexpected`.
- R6: A request with `ar_len` = N expects N+1 beats, and the beat with index N is the expected last beat. `err_length` is set in either of two cases: `r_last` is high on an earlier beat, or `r_last` is low on the expected last beat. The entry is retired on whichever of the two comes first.
- R7: Beat k of a request carries expected data (tag + k) mod 256. On a mismatch, `err_data` is set and `err_count` increases by one.
- R8: `err_count` saturates at 255.
- R9: A channel that has valid or ready low at the edge is ignored: nothing is recorded, checked or retired.
- R10: The synchronous active-high reset empties every queue and clears all flags and the counter. Outside reset, the flags stay high once set.
- R11: The error outputs are registered. A fault becomes visible just after the clock edge at which the offending handshake occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Request channel valid |
| ar_ready | input | 1 | Request channel ready |
| ar_id | input | ID_W | Request ID |
| ar_len | input | LEN_W | Request beats minus one |
| ar_tag | input | TAG_W | Request data signature tag |
| r_valid | input | 1 | Response channel valid |
| r_ready | input | 1 | Response channel ready |
| r_id | input | ID_W | Response ID |
| r_data | input | TAG_W | Response beat data |
| r_last | input | 1 | Response last-beat marker |
| err_overflow | output | 1 | Sticky: request dropped on a full queue |
| err_unexpected | output | 1 | Sticky: response with no pending request |
| err_length | output | 1 | Sticky: `r_last` early or missing |
| err_data | output | 1 | Sticky: beat data mismatch |
| err_count | output | CNT_W | Saturating count of data mismatches |

## Verification
The bound properties check the following on every cycle:
- the flags never drop without reset;
- the counter never falls and never moves by more than one per cycle;
- a response to an empty queue is always flagged one edge later;
- a request to a full queue is always flagged one edge later.

Other behaviour can only be shown by the bench's scenarios, because it needs a reference model of the queue contents:
- rejection of same-ID reordering and acceptance of cross-ID reordering and beat interleaving;
- the two length-fault shapes and retirement of the entry on either;
- dropping of an overflowed request;
- saturation of the counter;
- long random legal traffic with stalls, which must raise nothing.

// File: rtl/rdchk_pkg.sv
package rdchk_pkg;

  // One bit per fault class; shared by the top and the collector.
  typedef struct packed {
    logic overflow;
    logic unexpected;
    logic length;
    logic data;
  } rdchk_err_t;

endpackage

// File: rtl/rdchk_id_queue.sv
module rdchk_id_queue #(
  parameter int TAG_W = 8,
  parameter int LEN_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [LEN_W-1:0] push_len,
  input  logic             beat,
  input  logic             beat_last,
  output logic             empty,
  output logic             full,
  output logic [TAG_W-1:0] front_tag,
  output logic [LEN_W-1:0] front_len,
  output logic [LEN_W-1:0] beat_idx
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam int ENT_W = TAG_W + LEN_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign {front_tag, front_len} = mem[rd_ptr];

  assign do_push = push && !full;
  // An entry retires on the marked last beat or on its expected last beat.
  assign do_pop  = beat && !empty && (beat_last || (beat_idx == front_len));

  // Storage has no reset so it can map to a RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {push_tag, push_len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      beat_idx <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (do_pop)                 beat_idx <= '0;
      else if (beat && !empty)    beat_idx <= beat_idx + 1'b1;
    end
  end

endmodule

// File: rtl/rdchk_err_collect.sv
module rdchk_err_collect
  import rdchk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  rdchk_err_t       hit,
  output rdchk_err_t       sticky,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= '0;
      count  <= '0;
    end else begin
      sticky <= sticky | hit;
      if (hit.data && count != CNT_MAX) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/rd_order_checker.sv
module rd_order_checker
  import rdchk_pkg::*;
#(
  parameter int ID_W  = 2,
  parameter int TAG_W = 8,
  parameter int LEN_W = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [ID_W-1:0]  ar_id,
  input  logic [LEN_W-1:0] ar_len,
  input  logic [TAG_W-1:0] ar_tag,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic [ID_W-1:0]  r_id,
  input  logic [TAG_W-1:0] r_data,
  input  logic             r_last,
  output logic             err_overflow,
  output logic             err_unexpected,
  output logic             err_length,
  output logic             err_data,
  output logic [CNT_W-1:0] err_count
);

  localparam int NUM_IDS = 1 << ID_W;

  logic               ar_hs, r_hs;
  logic [NUM_IDS-1:0] q_empty, q_full;
  logic [TAG_W-1:0]   q_tag  [NUM_IDS];
  logic [LEN_W-1:0]   q_len  [NUM_IDS];
  logic [LEN_W-1:0]   q_beat [NUM_IDS];
  logic               sel_empty, exp_last;
  logic [TAG_W-1:0]   exp_data;
  rdchk_err_t         hit, sticky;

  assign ar_hs = ar_valid && ar_ready;
  assign r_hs  = r_valid && r_ready;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_q
    rdchk_id_queue #(.TAG_W(TAG_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .push      (ar_hs && (ar_id == ID_W'(i))),
      .push_tag  (ar_tag),
      .push_len  (ar_len),
      .beat      (r_hs && (r_id == ID_W'(i))),
      .beat_last (r_last),
      .empty     (q_empty[i]),
      .full      (q_full[i]),
      .front_tag (q_tag[i]),
      .front_len (q_len[i]),
      .beat_idx  (q_beat[i])
    );
  end

  assign sel_empty = q_empty[r_id];
  assign exp_last  = (q_beat[r_id] == q_len[r_id]);
  assign exp_data  = q_tag[r_id] + TAG_W'(q_beat[r_id]);

  always_comb begin
    hit            = '0;
    hit.overflow   = ar_hs && q_full[ar_id];
    hit.unexpected = r_hs && sel_empty;
    hit.length     = r_hs && !sel_empty && (r_last != exp_last);
    hit.data       = r_hs && !sel_empty && (r_data != exp_data);
  end

  rdchk_err_collect #(.CNT_W(CNT_W)) u_err (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .sticky (sticky),
    .count  (err_count)
  );

  assign err_overflow   = sticky.overflow;
  assign err_unexpected = sticky.unexpected;
  assign err_length     = sticky.length;
  assign err_data       = sticky.data;

endmodule

// File: rtl/rdchk_sva.sv
module rdchk_sva #(
  parameter int ID_W  = 2,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ar_valid,
  input logic                 ar_ready,
  input logic [ID_W-1:0]      ar_id,
  input logic                 r_valid,
  input logic                 r_ready,
  input logic [ID_W-1:0]      r_id,
  input logic [(1<<ID_W)-1:0] q_empty,
  input logic [(1<<ID_W)-1:0] q_full,
  input logic                 err_overflow,
  input logic                 err_unexpected,
  input logic                 err_length,
  input logic                 err_data,
  input logic [CNT_W-1:0]     err_count
);

  assert_overflow_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && q_full[ar_id]) |=> err_overflow);

  assert_unexpected_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && q_empty[r_id]) |=> err_unexpected);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  assert_count_hold_at_max_R8: assert property (@(posedge clk) disable iff (rst)
    (err_count == '1) |=> (err_count == '1));

  assert_sticky_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (err_overflow || err_unexpected || err_length || err_data) |=>
      ((err_overflow   || !$past(err_overflow)) &&
       (err_unexpected || !$past(err_unexpected)) &&
       (err_length     || !$past(err_length)) &&
       (err_data       || !$past(err_data))));

endmodule

bind rd_order_checker rdchk_sva #(.ID_W(ID_W), .CNT_W(CNT_W)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .ar_valid       (ar_valid),
  .ar_ready       (ar_ready),
  .ar_id          (ar_id),
  .r_valid        (r_valid),
  .r_ready        (r_ready),
  .r_id           (r_id),
  .q_empty        (q_empty),
  .q_full         (q_full),
  .err_overflow   (err_overflow),
  .err_unexpected (err_unexpected),
  .err_length     (err_length),
  .err_data       (err_data),
  .err_count      (err_count)
);

// File: tb/sim_rd_order_checker.sv
`timescale 1ns/1ps
module sim_rd_order_checker;

  logic       clk = 1'b0;
  logic       rst;
  logic       ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic [1:0] ar_id, r_id;
  logic [7:0] ar_len, ar_tag, r_data;
  logic       err_overflow, err_unexpected, err_length, err_data;
  logic [7:0] err_count;

  int checks = 0, failures = 0, cyc_n = 0;
  bit done = 0;

  logic [7:0] m_tag [4][4];
  logic [7:0] m_len [4][4];
  int m_hd [4], m_cnt [4], m_beat [4];

  always #2.5 clk = ~clk;

  rd_order_checker u0 (.*);

  function automatic logic [7:0] beat_data(input logic [7:0] tag, input int k);
    return tag + 8'(k);
  endfunction

  function automatic logic [3:0] err_vec();
    return {err_overflow, err_unexpected, err_length, err_data};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ar_valid = 0; ar_ready = 0; ar_id = 0; ar_len = 0; ar_tag = 0;
    r_valid = 0; r_ready = 0; r_id = 0; r_data = 0; r_last = 0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    cyc(); cyc();
    rst = 0;
    for (int i = 0; i < 4; i++) begin m_hd[i] = 0; m_cnt[i] = 0; m_beat[i] = 0; end
  endtask

  task automatic ar(input int id, input logic [7:0] tag, input logic [7:0] len);
    ar_valid = 1; ar_ready = 1; ar_id = 2'(id); ar_tag = tag; ar_len = len;
    cyc();
    ar_valid = 0; ar_ready = 0;
  endtask

  task automatic rb(input int id, input logic [7:0] data, input logic last);
    r_valid = 1; r_ready = 1; r_id = 2'(id); r_data = data; r_last = last;
    cyc();
    r_valid = 0; r_ready = 0; r_last = 0;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc_n);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R10: reset state
    check("R10 flags after reset", err_vec(), 4'b0000);
    check("R10 count after reset", err_count, 8'd0);

    // R10: reset empties the queues
    ar(0, 8'h11, 8'd0);
    do_reset();
    rb(0, 8'h11, 1);
    check("R10 queue emptied by reset", err_vec(), 4'b0100);

    // R3: ID0 issued first, ID1 answered first
    do_reset();
    ar(0, 8'h10, 8'd0);
    ar(1, 8'h20, 8'd0);
    rb(1, beat_data(8'h20, 0), 1);
    rb(0, beat_data(8'h10, 0), 1);
    check("R3 cross-ID reorder accepted", err_vec(), 4'b0000);

    // R3/R6/R1: beat interleave across two IDs, two-beat bursts
    ar(0, 8'h50, 8'd1);
    ar(1, 8'h60, 8'd1);
    rb(1, beat_data(8'h60, 0), 0);
    rb(0, beat_data(8'h50, 0), 0);
    rb(1, beat_data(8'h60, 1), 1);
    rb(0, beat_data(8'h50, 1), 1);
    check("R3 beat interleave accepted", err_vec(), 4'b0000);
    check("R1 count zero after legal traffic", err_count, 8'd0);

    // R2/R7/R11: same-ID reorder flagged, visible just after the edge
    do_reset();
    ar(2, 8'h30, 8'd0);
    ar(2, 8'h40, 8'd0);
    r_valid = 1; r_ready = 1; r_id = 2; r_data = 8'h40; r_last = 1;
    #1;
    check("R11 no flag before the edge", err_data, 1'b0);
    cyc();
    r_valid = 0; r_ready = 0; r_last = 0;
    check("R2 same-ID reorder flagged", err_data, 1'b1);
    check("R7 count incremented", err_count, 8'd1);

    // R4: fifth outstanding request overflows and is dropped
    do_reset();
    for (int i = 0; i < 5; i++) ar(3, 8'(i * 16), 8'd0);
    check("R4 overflow flagged", err_overflow, 1'b1);
    for (int i = 0; i < 4; i++) rb(3, beat_data(8'(i * 16), 0), 1);
    check("R4 four recorded entries match", {err_unexpected, err_length, err_data}, 3'b000);
    rb(3, beat_data(8'h40, 0), 1);
    check("R4 dropped request not recorded", err_unexpected, 1'b1);

    // R5: response with no pending request
    do_reset();
    rb(1, 8'h00, 1);
    check("R5 unexpected response", err_vec(), 4'b0100);

    // R6: early last
    do_reset();
    ar(0, 8'h05, 8'd2);
    rb(0, beat_data(8'h05, 0), 0);
    rb(0, beat_data(8'h05, 1), 1);
    check("R6 early last flagged", err_vec(), 4'b0010);
    rb(0, beat_data(8'h05, 2), 1);
    check("R6 entry retired on early last", err_unexpected, 1'b1);

    // R6: missing last
    do_reset();
    ar(2, 8'h07, 8'd0);
    rb(2, beat_data(8'h07, 0), 0);
    check("R6 missing last flagged", err_vec(), 4'b0010);
    rb(2, beat_data(8'h07, 1), 1);
    check("R6 entry retired on expected last", err_unexpected, 1'b1);

    // R9: incomplete handshakes ignored
    do_reset();
    ar(0, 8'h70, 8'd0);
    r_valid = 1; r_ready = 0; r_id = 0; r_data = 8'hFF; r_last = 0;
    cyc();
    r_valid = 0; r_ready = 1; r_id = 3;
    cyc();
    r_ready = 0;
    ar_valid = 1; ar_ready = 0; ar_id = 1; ar_tag = 8'h99;
    cyc();
    ar_valid = 0;
    check("R9 stalled beats ignored", err_vec(), 4'b0000);
    rb(0, beat_data(8'h70, 0), 1);
    check("R9 pending entry kept through stall", err_vec(), 4'b0000);
    rb(1, 8'h99, 1);
    check("R9 stalled request not recorded", err_unexpected, 1'b1);

    // R8: counter saturates
    do_reset();
    for (int i = 0; i < 260; i++) begin
      ar(0, 8'(i), 8'd0);
      rb(0, ~beat_data(8'(i), 0), 1);
    end
    check("R8 count saturated", err_count, 8'd255);

    // R1/R3/R6/R9: random legal traffic with stalls
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      int aid;
      int rid;
      aid = $urandom_range(0, 3);
      rid = $urandom_range(0, 3);
      ar_valid = ($urandom_range(0, 2) == 0) && (m_cnt[aid] < 4);
      ar_ready = $urandom_range(0, 1);
      ar_id = 2'(aid); ar_tag = 8'($urandom); ar_len = 8'($urandom_range(0, 3));
      r_valid = (m_cnt[rid] > 0) && ($urandom_range(0, 1) == 1);
      r_ready = ($urandom_range(0, 3) != 0);
      r_id = 2'(rid);
      r_data = beat_data(m_tag[rid][m_hd[rid]], m_beat[rid]);
      r_last = (8'(m_beat[rid]) == m_len[rid][m_hd[rid]]);
      cyc();
      if (r_valid && r_ready) begin
        if (r_last) begin
          m_hd[rid] = (m_hd[rid] + 1) % 4; m_cnt[rid]--; m_beat[rid] = 0;
        end else m_beat[rid]++;
      end
      if (ar_valid && ar_ready) begin
        m_tag[aid][(m_hd[aid] + m_cnt[aid]) % 4] = ar_tag;
        m_len[aid][(m_hd[aid] + m_cnt[aid]) % 4] = ar_len;
        m_cnt[aid]++;
      end
    end
    idle();
    for (int id = 0; id < 4; id++) begin
      while (m_cnt[id] > 0) begin
        logic lst;
        lst = (8'(m_beat[id]) == m_len[id][m_hd[id]]);
        rb(id, beat_data(m_tag[id][m_hd[id]], m_beat[id]), lst);
        if (lst) begin m_hd[id] = (m_hd[id] + 1) % 4; m_cnt[id]--; m_beat[id] = 0; end
        else m_beat[id]++;
      end
    end
    check("R3 random legal traffic raises nothing", err_vec(), 4'b0000);
    check("R1 random legal traffic count", err_count, 8'd0);
    rb(0, 8'h00, 1);
    check("R1 all queues drained", err_unexpected, 1'b1);

    report();
    $finish;
  end

endmodule